// File: doc/BRIEF.md
# Interrupt Cause and Moderation Controller

This block gathers interrupt causes from the receive and transmit sides of a network controller into a pending-cause register. It drives one level-sensitive interrupt line to the host whenever a pending cause is also enabled in a mask. Software enables and disables causes through separate mask-set and mask-clear strobes. Reading the cause register returns the pending bits and clears them.

Ordinary causes pass through a throttle. Once the line has risen, a throttle count runs, and ordinary causes posted in that window stay pending until the count runs out. Four delay timers handle receive delay, receive absolute delay, transmit delay and transmit absolute delay. When one of them expires, it posts its cause as an immediate post that ignores the throttle.

Every timer value is given in units of 1024 ns. The `TICK_DIV` parameter sets how many clock cycles make one unit. A unit value of V therefore lasts N = V*TICK_DIV cycles.

Top module: `irq_moderator`

## Requirements
- R1: After reset the pending register and the mask are all zero and `irq_o` is low.
- R2: A bit driven on `cause_i` sets the same bit of `cause_o` at the sampling edge, whether or not it is masked.
- R3: `irq_o` stays low while no pending cause is enabled in the mask.
- R4: With the throttle idle, an enabled ordinary post raises `irq_o` at its sampling edge.
- R5: A `rd_cause_i` strobe returns `cause_o` and clears it. With no post in the same cycle, `irq_o` is low after that edge.
- R6: Register writes use `wr_addr_i`: 0 sets mask bits, 1 clears mask bits, 2 loads the throttle value, 3 receive delay, 4 receive absolute delay, 5 transmit delay, 6 transmit absolute delay. A mask write raises `irq_o` at once if an enabled cause is pending, even while the throttle runs. It drops `irq_o` if no enabled cause remains.
- R7: When `irq_o` rises, the throttle loads N cycles. If the line rose at edge R, an enabled ordinary post held by the throttle raises `irq_o` at edge R+N+1. A throttle value of 0 holds nothing.
- R8: The receive delay timer starts or restarts on every `rx_pkt_i`. At edge E+N+1 after the last such event, it sets cause bit `RX_BIT` (default 4) with the immediate flag.
- R9: The receive absolute timer starts on the first `rx_pkt_i` while idle and ignores later events. It posts bit `RX_BIT` at E+N+1 of the first event.
- R10: The transmit delay and transmit absolute timers follow R8 and R9 on `tx_desc_i`. They post bit `TX_BIT` (default 0).
- R11: An enabled timer post raises `irq_o` even while the throttle is running.
- R12: Writing 0 to a timer stops it, and no post follows. Writing a non-zero value to a running timer restarts it at the new value, so it posts at W+N+1 after the write edge W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register select |
| wr_data_i | input | DATA_W | Write data |
| cause_i | input | NUM_CAUSES | Ordinary cause event pulses |
| rx_pkt_i | input | 1 | Receive packet event for the receive timers |
| tx_desc_i | input | 1 | Transmit descriptor event for the transmit timers |
| rd_cause_i | input | 1 | Cause read strobe, clears the pending bits |
| cause_o | output | NUM_CAUSES | Pending cause bits |
| irq_o | output | 1 | Level interrupt line |

## Verification
Ordinary posts, mask writes and reads take effect at the edge that samples them, and the bench checks them one nanosecond after that edge. A timer event at edge E is due at E+N+1. A throttled post after a rise at edge R is due at E=R+N+1. The bench therefore checks that `irq_o` is low at every edge up to the one before, and high at the due edge. All counts are computed from the small bench configuration (TICK_DIV=3), independently of the design.

// File: rtl/irq_mod_pkg.sv
package irq_mod_pkg;
  localparam logic [2:0] REG_MASK_SET = 3'd0;
  localparam logic [2:0] REG_MASK_CLR = 3'd1;
  localparam logic [2:0] REG_THROTTLE = 3'd2;
  localparam logic [2:0] REG_RX_DLY   = 3'd3;
  localparam logic [2:0] REG_RX_ABS   = 3'd4;
  localparam logic [2:0] REG_TX_DLY   = 3'd5;
  localparam logic [2:0] REG_TX_ABS   = 3'd6;
  localparam int NUM_TIMERS = 4;
endpackage

// File: rtl/irq_delay_timer.sv
module irq_delay_timer #(
  parameter int TIMER_W  = 16,
  parameter int TICK_DIV = 205,
  parameter bit RESTART  = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [TIMER_W-1:0] val_i,
  input  logic               event_i,
  output logic               expire_o
);
  localparam int CW = TIMER_W + $clog2(TICK_DIV + 1);

  logic [TIMER_W-1:0] val_q;
  logic [CW-1:0]      cnt_q;
  logic               run_q, expire_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q    <= '0;
      cnt_q    <= '0;
      run_q    <= 1'b0;
      expire_q <= 1'b0;
    end else begin
      expire_q <= 1'b0;
      if (load_i) begin
        val_q <= val_i;
        if (run_q) begin
          cnt_q <= CW'(val_i) * CW'(TICK_DIV);
          run_q <= (val_i != '0);
        end
      end else if (event_i && val_q != '0 && (RESTART || !run_q)) begin
        cnt_q <= CW'(val_q) * CW'(TICK_DIV);
        run_q <= 1'b1;
      end else if (run_q) begin
        if (cnt_q == CW'(1)) begin
          cnt_q    <= '0;
          run_q    <= 1'b0;
          expire_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - CW'(1);
        end
      end
    end
  end

  assign expire_o = expire_q;

  p_zero_never_fires_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (val_q == '0 && !run_q && !load_i) |=> !expire_q);
  p_single_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_q |=> !expire_q);
endmodule

// File: rtl/irq_throttle.sv
module irq_throttle #(
  parameter int TIMER_W  = 16,
  parameter int TICK_DIV = 205
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [TIMER_W-1:0] val_i,
  input  logic               rise_i,
  output logic               idle_o
);
  localparam int CW = TIMER_W + $clog2(TICK_DIV + 1);

  logic [TIMER_W-1:0] val_q;
  logic [CW-1:0]      cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      val_q <= val_i;
      if (cnt_q != '0) cnt_q <= CW'(val_i) * CW'(TICK_DIV);
    end else if (rise_i) begin
      cnt_q <= CW'(val_q) * CW'(TICK_DIV);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign idle_o = (cnt_q == '0);

  p_reload_on_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && !load_i && val_q != '0) |=> !idle_o);
endmodule

// File: rtl/irq_cause_reg.sv
module irq_cause_reg #(
  parameter int NUM_CAUSES = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_CAUSES-1:0] post_i,
  input  logic [NUM_CAUSES-1:0] imm_i,
  input  logic                  rd_i,
  input  logic                  mask_set_i,
  input  logic                  mask_clr_i,
  input  logic [NUM_CAUSES-1:0] mask_data_i,
  input  logic                  thr_idle_i,
  output logic [NUM_CAUSES-1:0] pend_o,
  output logic                  line_o,
  output logic                  rise_o
);
  logic [NUM_CAUSES-1:0] pend_q, pend_nxt, mask_q, mask_nxt;
  logic line_q, line_nxt, any_en, imm_hit;

  always_comb begin
    mask_nxt = mask_q;
    if (mask_set_i) mask_nxt = mask_nxt | mask_data_i;
    if (mask_clr_i) mask_nxt = mask_nxt & ~mask_data_i;
    pend_nxt = (rd_i ? '0 : pend_q) | post_i | imm_i;
    any_en   = |(pend_nxt & mask_nxt);
    imm_hit  = |(imm_i & mask_nxt);
    // ordinary causes wait for the throttle; immediates and mask writes do not
    line_nxt = any_en & (line_q | imm_hit | mask_set_i | mask_clr_i | thr_idle_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      mask_q <= '0;
      line_q <= 1'b0;
    end else begin
      pend_q <= pend_nxt;
      mask_q <= mask_nxt;
      line_q <= line_nxt;
    end
  end

  assign pend_o = pend_q;
  assign line_o = line_q;
  assign rise_o = line_nxt & ~line_q;

  p_line_needs_enabled_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_q |-> |(pend_q & mask_q));
  p_post_sets_pending_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|post_i) |=> ((pend_q & $past(post_i)) == $past(post_i)));
  p_read_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && post_i == '0 && imm_i == '0) |=> (pend_q == '0 && !line_q));
  p_hold_throttled_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!line_q && !thr_idle_i && (imm_i & mask_q) == '0 && !mask_set_i && !mask_clr_i)
      |=> !line_q);
endmodule

// File: rtl/irq_moderator.sv
module irq_moderator
  import irq_mod_pkg::*;
#(
  parameter int NUM_CAUSES = 16,
  parameter int TIMER_W    = 16,
  parameter int DATA_W     = 16,
  parameter int TICK_DIV   = 205,
  parameter int RX_BIT     = 4,
  parameter int TX_BIT     = 0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [2:0]            wr_addr_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  input  logic [NUM_CAUSES-1:0] cause_i,
  input  logic                  rx_pkt_i,
  input  logic                  tx_desc_i,
  input  logic                  rd_cause_i,
  output logic [NUM_CAUSES-1:0] cause_o,
  output logic                  irq_o
);
  logic [NUM_TIMERS-1:0] tmr_exp;
  logic [NUM_CAUSES-1:0] imm_post;
  logic thr_idle, line_rise;

  generate
    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
      localparam logic [2:0] ADDR = 3'(int'(REG_RX_DLY) + g);
      localparam bit IS_DELAY = (g % 2 == 0);
      logic ev;
      if (g < 2) begin : g_rx
        assign ev = rx_pkt_i;
      end else begin : g_tx
        assign ev = tx_desc_i;
      end
      irq_delay_timer #(
        .TIMER_W (TIMER_W),
        .TICK_DIV(TICK_DIV),
        .RESTART (IS_DELAY)
      ) u_tmr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (wr_en_i && wr_addr_i == ADDR),
        .val_i   (wr_data_i[TIMER_W-1:0]),
        .event_i (ev),
        .expire_o(tmr_exp[g])
      );
    end
  endgenerate

  always_comb begin
    imm_post         = '0;
    imm_post[RX_BIT] = tmr_exp[0] | tmr_exp[1];
    imm_post[TX_BIT] = imm_post[TX_BIT] | tmr_exp[2] | tmr_exp[3];
  end

  irq_throttle #(
    .TIMER_W (TIMER_W),
    .TICK_DIV(TICK_DIV)
  ) u_thr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(wr_en_i && wr_addr_i == REG_THROTTLE),
    .val_i (wr_data_i[TIMER_W-1:0]),
    .rise_i(line_rise),
    .idle_o(thr_idle)
  );

  irq_cause_reg #(
    .NUM_CAUSES(NUM_CAUSES)
  ) u_cause (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .post_i     (cause_i),
    .imm_i      (imm_post),
    .rd_i       (rd_cause_i),
    .mask_set_i (wr_en_i && wr_addr_i == REG_MASK_SET),
    .mask_clr_i (wr_en_i && wr_addr_i == REG_MASK_CLR),
    .mask_data_i(wr_data_i[NUM_CAUSES-1:0]),
    .thr_idle_i (thr_idle),
    .pend_o     (cause_o),
    .line_o     (irq_o),
    .rise_o     (line_rise)
  );

  p_timer_post_bypasses_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|tmr_exp && !rd_cause_i && !wr_en_i) |=> cause_o[$past(tmr_exp[0] | tmr_exp[1]) ? RX_BIT : TX_BIT]);
endmodule

// File: tb/irq_moderator_tb.sv
module irq_moderator_tb;
  localparam int NC = 8;
  localparam int TW = 8;
  localparam int DIV = 3;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic wr_en_i = 1'b0, rx_pkt_i = 1'b0, tx_desc_i = 1'b0, rd_cause_i = 1'b0;
  logic [2:0]    wr_addr_i = '0;
  logic [TW-1:0] wr_data_i = '0;
  logic [NC-1:0] cause_i = '0, cause_o;
  logic irq_o;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  irq_moderator #(.NUM_CAUSES(NC), .TIMER_W(TW), .DATA_W(TW), .TICK_DIV(DIV),
                  .RX_BIT(4), .TX_BIT(0)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .cause_i(cause_i), .rx_pkt_i(rx_pkt_i),
    .tx_desc_i(tx_desc_i), .rd_cause_i(rd_cause_i), .cause_o(cause_o), .irq_o(irq_o));

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [TW-1:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d; tick(); wr_en_i = 1'b0;
  endtask

  task automatic post(logic [NC-1:0] b);
    cause_i = b; tick(); cause_i = '0;
  endtask

  task automatic rd();
    rd_cause_i = 1'b1; tick(); rd_cause_i = 1'b0;
  endtask

  task automatic rx_ev();
    rx_pkt_i = 1'b1; tick(); rx_pkt_i = 1'b0;
  endtask

  task automatic tx_ev();
    tx_desc_i = 1'b1; tick(); tx_desc_i = 1'b0;
  endtask

  // n edges with line low, then the due edge with line and bit high
  task automatic expect_due(int n, int bitpos, string req);
    for (int i = 0; i < n; i++) begin
      tick(); chk(req, 32'(irq_o), 32'd0);
    end
    tick();
    chk(req, 32'(irq_o), 32'd1);
    chk(req, 32'(cause_o[bitpos]), 32'd1);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    chk("R1", 32'(cause_o), 32'd0);
    chk("R1", 32'(irq_o), 32'd0);

    // R2/R3/R4/R5 sweep over every cause bit, masked and enabled
    for (int b = 0; b < NC; b++) begin
      for (int m = 0; m < 2; m++) begin
        if (m == 1) wr(3'd0, TW'(1 << b));
        post(NC'(1 << b));
        chk("R2", 32'(cause_o), 32'(1 << b));
        chk(m == 1 ? "R4" : "R3", 32'(irq_o), 32'(m));
        rd();
        chk("R5", 32'(cause_o), 32'd0);
        chk("R5", 32'(irq_o), 32'd0);
        if (m == 1) wr(3'd1, TW'(1 << b));
      end
    end

    wr(3'd0, 8'h13);

    // R7: throttle 2 units = 6 cycles; rise at R, held post rises at R+7
    wr(3'd2, 8'd2);
    post(8'h02);
    chk("R7", 32'(irq_o), 32'd1);
    rd();
    post(8'h02);
    chk("R7", 32'(irq_o), 32'd0);
    expect_due(4, 1, "R7");
    rd();
    wr(3'd2, 8'd0);
    post(8'h02);
    chk("R7", 32'(irq_o), 32'd1);
    rd();

    // R6: mask writes bypass the throttle
    wr(3'd2, 8'd20);
    post(8'h02);
    rd();
    post(8'h08);
    chk("R6", 32'(irq_o), 32'd0);
    chk("R6", 32'(cause_o), 32'h08);
    wr(3'd0, 8'h08);
    chk("R6", 32'(irq_o), 32'd1);
    wr(3'd1, 8'h08);
    chk("R6", 32'(irq_o), 32'd0);
    rd();

    // R11: throttle still running; transmit delay 1 unit = 3 cycles
    post(8'h02);
    chk("R11", 32'(irq_o), 32'd0);
    rd();
    wr(3'd5, 8'd1);
    tx_ev();
    expect_due(3, 0, "R11");
    rd();
    wr(3'd5, 8'd0);
    wr(3'd2, 8'd0);

    // R8: receive delay 2 units, restarted by second event
    wr(3'd3, 8'd2);
    rx_ev(); tick(); tick(); rx_ev();
    expect_due(6, 4, "R8");
    rd();
    wr(3'd3, 8'd0);

    // R9: receive absolute 3 units = 9 cycles from first event
    wr(3'd4, 8'd3);
    rx_ev(); tick(); tick(); rx_ev();
    expect_due(6, 4, "R9");
    rd();
    wr(3'd4, 8'd0);

    // R10: transmit delay and absolute
    wr(3'd5, 8'd1);
    tx_ev();
    expect_due(3, 0, "R10");
    rd();
    wr(3'd5, 8'd0);
    wr(3'd6, 8'd2);
    tx_ev(); tx_ev();
    expect_due(5, 0, "R10");
    rd();
    wr(3'd6, 8'd0);

    // R12: reload while running, then zero stops the timer
    wr(3'd3, 8'd4);
    rx_ev(); tick();
    wr(3'd3, 8'd1);
    expect_due(3, 4, "R12");
    rd();
    wr(3'd3, 8'd5);
    rx_ev(); tick();
    wr(3'd3, 8'd0);
    rx_ev();
    for (int i = 0; i < 25; i++) begin
      tick();
      chk("R12", 32'(irq_o), 32'd0);
    end
    chk("R12", 32'(cause_o), 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule